// File: doc/BRIEF.md
# Cascadable Up/Down Binary Counter Chain

The block is a synchronous binary counter built from identical 4-bit stages. Each stage counts up or down on every rising clock edge while its active-low carry input is low, and holds while it is high. Each stage drives an active-low carry output. That output is low only when the stage sits at its terminal value for the selected direction and its own carry input is low. Chaining the carry output of one stage into the carry input of the next more significant stage gives a wider counter. All stages share one clock, so every stage updates on the same edge and no stage is clocked from another stage's output.

The top level chains two such stages into an 8-bit counter. The external count enable first passes through a D flip-flop clocked by the counter clock, so it never reaches the carry inputs of the stages asynchronously. The least significant stage counts only when this registered enable is low and a direct cascade input is also low. The cascade input is not registered. It lets a less significant counter of the same kind drive this chain, and it propagates combinationally to the chain's carry output.

Top module: `updn_chain`

## Requirements
- R1: While `rst` is high at a rising edge, that edge clears the count to 0 and sets the registered enable to its inactive (high) level. On the first edge after reset is released, the count therefore stays at 0 even when `en_n` is low.
- R2: When the registered enable and `carry_in_n` are both low, each rising edge changes the 8-bit count by one. With `dir_up` = 1 the count goes up by one, and with `dir_up` = 0 it goes down by one.
- R3: When the registered enable is high or `carry_in_n` is high at a rising edge, the count keeps its value.
- R4: `en_n` takes effect through a flip-flop. Its level at one rising edge decides whether the count moves at the following edge.
- R5: The count wraps around: 255 goes to 0 when counting up, and 0 goes to 255 when counting down.
- R6: `carry_out_n` is 0 exactly when the registered enable is low, `carry_in_n` is low, and the count is at its terminal value. The terminal value is 255 when `dir_up` = 1 and 0 when `dir_up` = 0. In every other case `carry_out_n` is 1.
- R7: `carry_out_n` follows changes on `carry_in_n` and `dir_up` within the same clock period, without waiting for a clock edge.
- R8: When counting up from a value whose low nibble is 15, the high nibble goes up by one on the same edge that clears the low nibble. For example, 0x0F goes to 0x10.
- R9: `count` changes only at a rising clock edge. Changes on `carry_in_n`, `dir_up` or `en_n` between edges leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter clock, shared by all stages |
| rst | input | 1 | Synchronous active-high reset |
| dir_up | input | 1 | Direction select: 1 counts up, 0 counts down |
| en_n | input | 1 | Active-low count enable, registered before use |
| carry_in_n | input | 1 | Active-low cascade input from a less significant counter, not registered |
| count | output | 8 | Current count; bits 3:0 come from the low stage, bits 7:4 from the high stage |
| carry_out_n | output | 1 | Active-low terminal-count carry to a more significant counter |

## Verification
The bound checker watches the clock-to-clock behaviour on every cycle. It checks the reset value, the one-cycle delay of the enable register, holding, stepping up or down by one with wraparound, the high nibble advancing together with the low nibble, and the carry output as a function of count, direction and enable at each edge. Assertions sample only at edges, so only the bench's scenarios show that the carry output reacts to `carry_in_n` and `dir_up` between edges while the count stays still. The bench does this by toggling those inputs in mid-cycle during full up and down sweeps, and during a pseudo-random stretch of enable and direction changes.

// File: rtl/updn_pkg.sv
package updn_pkg;

    // Direction encoding on dir_up
    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

    // Enable register state
    typedef struct packed {
        logic en_n;
    } en_state_t;

endpackage

// File: rtl/updn_en_sync.sv
module updn_en_sync
    import updn_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en_n,
    output logic en_q_n
);

    en_state_t st_d;
    en_state_t st_q;

    always_comb begin
        st_d      = st_q;
        st_d.en_n = en_n;
        if (rst) begin
            st_d.en_n = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign en_q_n = st_q.en_n;

endmodule

// File: rtl/updn_stage.sv
module updn_stage
    import updn_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         dir_up,
    input  logic         ci_n,
    output logic [W-1:0] q,
    output logic         co_n
);

    localparam logic [W-1:0] ONE    = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] TOP    = {W{1'b1}};
    localparam logic [W-1:0] BOTTOM = '0;

    typedef struct packed {
        logic [W-1:0] cnt;
    } stage_state_t;

    stage_state_t st_d;
    stage_state_t st_q;
    logic         at_tc;

    always_comb begin
        st_d = st_q;
        if (!ci_n) begin
            if (dir_e'(dir_up) == DIR_UP) begin
                st_d.cnt = st_q.cnt + ONE;
            end else begin
                st_d.cnt = st_q.cnt - ONE;
            end
        end
        if (rst) begin
            st_d.cnt = BOTTOM;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // Terminal value depends on the direction applied right now
    always_comb begin
        if (dir_e'(dir_up) == DIR_UP) begin
            at_tc = (st_q.cnt == TOP);
        end else begin
            at_tc = (st_q.cnt == BOTTOM);
        end
    end

    assign co_n = ci_n | ~at_tc;
    assign q    = st_q.cnt;

endmodule

// File: rtl/updn_chain.sv
module updn_chain #(
    parameter int STAGE_W    = 4,
    parameter int NUM_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          dir_up,
    input  logic                          en_n,
    input  logic                          carry_in_n,
    output logic [STAGE_W*NUM_STAGES-1:0] count,
    output logic                          carry_out_n
);

    localparam int CW = STAGE_W * NUM_STAGES;

    logic                  en_q_n;
    logic [NUM_STAGES:0]   carry_n;

    updn_en_sync u_en (
        .clk    (clk),
        .rst    (rst),
        .en_n   (en_n),
        .en_q_n (en_q_n)
    );

    assign carry_n[0] = en_q_n | carry_in_n;

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
        updn_stage #(
            .W (STAGE_W)
        ) u_stage (
            .clk    (clk),
            .rst    (rst),
            .dir_up (dir_up),
            .ci_n   (carry_n[g]),
            .q      (count[g*STAGE_W +: STAGE_W]),
            .co_n   (carry_n[g+1])
        );
    end

    assign carry_out_n = carry_n[NUM_STAGES];

endmodule

// File: rtl/updn_chain_chk.sv
module updn_chain_chk #(
    parameter int STAGE_W    = 4,
    parameter int NUM_STAGES = 2
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          dir_up,
    input logic                          en_n,
    input logic                          carry_in_n,
    input logic                          en_q_n,
    input logic [STAGE_W*NUM_STAGES-1:0] count,
    input logic                          carry_out_n
);

    localparam int CW = STAGE_W * NUM_STAGES;
    localparam int UW = CW - STAGE_W;
    localparam logic [CW-1:0]      ONE_C  = {{(CW-1){1'b0}}, 1'b1};
    localparam logic [UW-1:0]      ONE_U  = {{(UW-1){1'b0}}, 1'b1};
    localparam logic [STAGE_W-1:0] LO_TOP = {STAGE_W{1'b1}};

    logic seen_q = 1'b0;
    logic run;

    always_ff @(posedge clk) begin
        if (rst) seen_q <= 1'b1;
    end

    assign run = seen_q && !en_q_n && !carry_in_n;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (count == '0 && en_q_n));

    assert_enable_delay_R4: assert property (@(posedge clk) disable iff (rst)
        seen_q |=> (en_q_n == $past(en_n)));

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (seen_q && (en_q_n || carry_in_n)) |=> (count == $past(count)));

    assert_step_up_R2: assert property (@(posedge clk) disable iff (rst)
        (run && dir_up) |=> (count == $past(count) + ONE_C));

    assert_step_down_R2: assert property (@(posedge clk) disable iff (rst)
        (run && !dir_up) |=> (count == $past(count) - ONE_C));

    assert_wrap_up_R5: assert property (@(posedge clk) disable iff (rst)
        (run && dir_up && (&count)) |=> (count == '0));

    assert_wrap_down_R5: assert property (@(posedge clk) disable iff (rst)
        (run && !dir_up && count == '0) |=> (&count));

    assert_cascade_R8: assert property (@(posedge clk) disable iff (rst)
        (run && dir_up && count[STAGE_W-1:0] == LO_TOP)
        |=> (count[STAGE_W-1:0] == '0
             && count[CW-1:STAGE_W] == $past(count[CW-1:STAGE_W]) + ONE_U));

    assert_carry_level_R6: assert property (@(posedge clk) disable iff (rst)
        seen_q |-> (carry_out_n == !(run && (dir_up ? (&count) : (count == '0)))));

endmodule

bind updn_chain updn_chain_chk #(
    .STAGE_W    (STAGE_W),
    .NUM_STAGES (NUM_STAGES)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .dir_up      (dir_up),
    .en_n        (en_n),
    .carry_in_n  (carry_in_n),
    .en_q_n      (en_q_n),
    .count       (count),
    .carry_out_n (carry_out_n)
);

// File: tb/sim_updn_chain.sv
`timescale 1ns/1ps
module sim_updn_chain;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dir_up = 1'b1;
    logic       en_n = 1'b1;
    logic       carry_in_n = 1'b1;
    logic [7:0] count;
    logic       carry_out_n;

    int n_chk  = 0;
    int n_fail = 0;

    // Reference model state
    int   m_cnt = 0;
    logic m_enq = 1'b1;
    int   prev_cnt = 0;

    always #5 clk = ~clk;

    updn_chain u0 (
        .clk         (clk),
        .rst         (rst),
        .dir_up      (dir_up),
        .en_n        (en_n),
        .carry_in_n  (carry_in_n),
        .count       (count),
        .carry_out_n (carry_out_n)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0;
            m_enq = 1'b1;
        end else begin
            if (!(m_enq || carry_in_n))
                m_cnt = (m_cnt + (dir_up ? 1 : 255)) % 256;
            m_enq = en_n;
        end
    end

    function automatic logic exp_co(input logic d, input logic ci);
        logic tc;
        tc = d ? (m_cnt == 255) : (m_cnt == 0);
        return !(!m_enq && !ci && tc);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // One clock period: check state at the falling edge, apply new inputs,
    // then toggle cascade input and direction mid-cycle and check carry.
    task automatic cycle(input logic d, input logic e, input logic ci);
        string lbl;
        @(negedge clk);
        if (m_cnt == prev_cnt) lbl = "R3 hold";
        else if ((prev_cnt == 255 && m_cnt == 0) || (prev_cnt == 0 && m_cnt == 255)) lbl = "R5 wrap";
        else if (prev_cnt % 16 == 15 && m_cnt == prev_cnt + 1) lbl = "R8 cascade";
        else lbl = "R2 step";
        chk(lbl, count, m_cnt);
        chk("R6 carry level", carry_out_n, exp_co(dir_up, carry_in_n));
        prev_cnt = m_cnt;
        dir_up = d; en_n = e; carry_in_n = ci;
        #1;
        chk("R7 carry after input change", carry_out_n, exp_co(d, ci));
        chk("R9 count stable between edges", count, m_cnt);
        carry_in_n = ~ci;
        #1;
        chk("R7 carry follows carry_in_n", carry_out_n, exp_co(d, ~ci));
        carry_in_n = ci;
        dir_up = ~d;
        #1;
        chk("R7 carry follows dir_up", carry_out_n, exp_co(~d, ci));
        chk("R9 count stable after toggles", count, m_cnt);
        dir_up = d;
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual run still busy, expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        repeat (3) @(negedge clk);
        chk("R1 reset count", count, 0);
        chk("R1 reset carry", carry_out_n, 1);
        // release reset with enable already asserted
        rst = 1'b0; en_n = 1'b0; carry_in_n = 1'b0; dir_up = 1'b1;
        @(negedge clk);
        chk("R1 first edge after reset holds", count, 0);
        @(negedge clk);
        chk("R4 enable active one edge later", count, 1);
        prev_cnt = m_cnt;
        // full up sweep with wrap and nibble carries
        for (int i = 0; i < 270; i++) cycle(1'b1, 1'b0, 1'b0);
        // full down sweep with wrap
        for (int i = 0; i < 270; i++) cycle(1'b0, 1'b0, 1'b0);
        // enable deasserted: registered hold
        for (int i = 0; i < 5; i++) cycle(1'b1, 1'b1, 1'b0);
        // cascade input high: hold
        for (int i = 0; i < 5; i++) cycle(1'b1, 1'b0, 1'b1);
        // pseudo-random enable, cascade and direction
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cycle(lfsr[0] | lfsr[1], lfsr[2] & lfsr[3], lfsr[4] & lfsr[5] & lfsr[6]);
        end
        // mid-run reset
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 mid-run reset count", count, 0);
        rst = 1'b0; en_n = 1'b0; carry_in_n = 1'b0; dir_up = 1'b0;
        @(negedge clk);
        chk("R1 hold on first edge after reset", count, 0);
        @(negedge clk);
        chk("R5 down from zero after reset", count, 255);
        chk("R6 carry idle at 255 counting down", carry_out_n, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule